// File: doc/BRIEF.md
# Laser Array Enable and Status Controller

This block decides, once per clock, whether the laser array of a parallel optical transmitter may be driven, and it reports whether the laser control is up. Three external control pins feed it: an active-low reset, an active-high enable and an active-low enable. A supply-good input, a laser fault indication and one alerter verdict per channel feed it as well. All pins and the supply and fault inputs pass through two-flop synchronisers before they are used.

A detected fault is latched. The lasers stay dark and the status output stays low until the control reset pin is held low for at least `MIN_LOW_CYC` consecutive synchronised cycles. A shorter low pulse still turns the lasers off while it lasts, but the fault survives it. Each channel's drive enable is the global enable gated by that channel's alerter verdict, so a channel flagged by its alerter, or left unused, stays quiescent.

Top module: `lec_top`

## Requirements
- R1: The global laser enable is on only when supply-good is 1, the reset pin is 1, the high-active enable is 1, the low-active enable is 0 and no fault is latched. Every other combination turns all drive enables off.
- R2: A 0 on the reset pin turns every drive enable off, whatever the other inputs are.
- R3: The controller-up output is 1 when supply-good is 1, the reset pin is 1 and no fault is latched. It is 0 while a fault is latched or the reset pin is low. The enable pins have no effect on it.
- R4: While supply-good is 0, all drive enables and the controller-up output are 0.
- R5: A 1 on the fault input latches a fault that persists after the fault input returns to 0.
- R6: A latched fault is cleared only by a reset-pin low pulse of at least `MIN_LOW_CYC` cycles. A pulse of `MIN_LOW_CYC`-1 cycles leaves the fault latched. Without a fault, a short pulse only disables the lasers while it is low.
- R7: Drive enable bit i equals the global enable ANDed with alerter bit i. Channels do not affect one another.
- R8: A change on any control pin reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages and one output register.
- R9: After chip reset, all drive enables and the controller-up output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| supply_ok | input | 1 | Supply has reached operating level |
| laser_rst_n | input | 1 | Control reset pin, active low |
| laser_en | input | 1 | Laser enable pin, active high |
| laser_en_n | input | 1 | Laser enable pin, active low |
| fault_in | input | 1 | Laser fault indication |
| alert_ok | input | NCH | Per-channel alerter verdict, 1 = channel may emit |
| drive_en | output | NCH | Per-channel laser drive enable |
| ctrl_up | output | 1 | Laser controller up status |

## Verification
On every cycle, the assertions check the following. A synchronised reset low or a missing supply blanks all outputs on the next cycle. A synchronised fault pulls the status low. A latched fault is only ever released after the low-width counter has saturated. The counter never passes its limit. Only the bench scenarios can show the exact three-edge latency, the full truth table of the mixed-polarity enables, and the difference between pulses of `MIN_LOW_CYC`-1 and `MIN_LOW_CYC` cycles. They also show that a fault survives its source going away and that channels gate independently.

// File: rtl/lec_pkg.sv
package lec_pkg;
  // synchronised control bundle; bit order is fixed by the packing below
  typedef struct packed {
    logic sup;    // supply good
    logic rst_n;  // control reset, active low
    logic en;     // enable, active high
    logic en_n;   // enable, active low
    logic flt;    // fault indication
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  // safe value while the chip reset is asserted: everything off
  localparam ctl_t CTL_SAFE = '{sup: 1'b0, rst_n: 1'b0, en: 1'b0, en_n: 1'b1, flt: 1'b0};
endpackage

// File: rtl/lec_sync.sv
module lec_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/lec_fault.sv
module lec_fault #(
  parameter int MIN_LOW_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_rst_n,
  input  logic s_flt,
  output logic fault_d,
  output logic fault_q
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          clr;

  // count cycles of reset low, saturating at the limit
  always_comb begin
    cnt_en = 1'b1;
    if (s_rst_n)              cnt_d = '0;
    else if (cnt_q == CNT_MAX) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
    else                      cnt_d = cnt_q + 1'b1;
  end

  // release pulse on the cycle the low time reaches the limit
  assign clr     = !s_rst_n && (cnt_q == CNT_LAST);
  assign fault_d = s_flt || (fault_q && !clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  // R6: a fault is only released once the low-width counter saturated
  a_r6_release_after_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> (cnt_q == CNT_MAX));
  // R6: counter stays within its limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R5: a synchronised fault is latched on the next cycle
  a_r5_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
    s_flt |=> fault_q);
endmodule

// File: rtl/lec_gate.sv
module lec_gate
  import lec_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ctl_t           s,
  input  logic           fault_d,
  input  logic [NCH-1:0] alert_ok,
  output logic [NCH-1:0] drive_en,
  output logic           ctrl_up
);
  logic en_d, en_q;
  logic up_d, up_q;

  always_comb begin
    up_d = s.sup && s.rst_n && !fault_d;
    en_d = up_d && s.en && !s.en_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      up_q <= 1'b0;
    end else begin
      en_q <= en_d;
      up_q <= up_d;
    end
  end

  assign ctrl_up = up_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign drive_en[i] = en_q && alert_ok[i];
  end

  // R4: no supply means nothing driven and status down next cycle
  a_r4_supply_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !s.sup |=> (!en_q && !up_q));
  // R3: a synchronised fault pulls status down next cycle
  a_r3_fault_drops_up: assert property (@(posedge clk) disable iff (!rst_n)
    s.flt |=> !up_q);
endmodule

// File: rtl/lec_top.sv
module lec_top
  import lec_pkg::*;
#(
  parameter int NCH         = 12,
  parameter int MIN_LOW_CYC = 2500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           supply_ok,
  input  logic           laser_rst_n,
  input  logic           laser_en,
  input  logic           laser_en_n,
  input  logic           fault_in,
  input  logic [NCH-1:0] alert_ok,
  output logic [NCH-1:0] drive_en,
  output logic           ctrl_up
);
  ctl_t raw, s;
  logic fault_d, fault_q;

  assign raw = '{sup: supply_ok, rst_n: laser_rst_n, en: laser_en,
                 en_n: laser_en_n, flt: fault_in};

  lec_sync #(.W(CTL_W), .RST_VAL(CTL_SAFE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s)
  );

  lec_fault #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_fault (
    .clk(clk), .rst_n(rst_n), .s_rst_n(s.rst_n), .s_flt(s.flt),
    .fault_d(fault_d), .fault_q(fault_q)
  );

  lec_gate #(.NCH(NCH)) u_gate (
    .clk(clk), .rst_n(rst_n), .s(s), .fault_d(fault_d),
    .alert_ok(alert_ok), .drive_en(drive_en), .ctrl_up(ctrl_up)
  );

  // R2: synchronised reset low blanks every channel next cycle
  a_r2_reset_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    !s.rst_n |=> (drive_en == '0 && !ctrl_up));
  // R1: a latched fault keeps every channel dark
  a_r1_fault_dark: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (drive_en == '0));
endmodule

// File: tb/lec_top_test.sv
module lec_top_test;
  localparam int NCH = 12;
  localparam int MIN = 2500;
  localparam logic [NCH-1:0] ALL = '1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           supply_ok, laser_rst_n, laser_en, laser_en_n, fault_in;
  logic [NCH-1:0] alert_ok;
  logic [NCH-1:0] drive_en;
  logic           ctrl_up;
  int             n_run = 0;
  int             n_fail = 0;
  bit             done = 1'b0;

  always #2 clk = ~clk;

  lec_top #(.NCH(NCH), .MIN_LOW_CYC(MIN)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .laser_rst_n(laser_rst_n),
    .laser_en(laser_en), .laser_en_n(laser_en_n), .fault_in(fault_in),
    .alert_ok(alert_ok), .drive_en(drive_en), .ctrl_up(ctrl_up)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic nominal();
    supply_ok = 1; laser_rst_n = 1; laser_en = 1; laser_en_n = 0;
    fault_in = 0; alert_ok = ALL;
    cyc(4);
  endtask

  task automatic t_reset_state();
    rst_n = 0; supply_ok = 1; laser_rst_n = 1; laser_en = 1; laser_en_n = 0;
    fault_in = 0; alert_ok = ALL;
    cyc(2);
    chk("R9 drive", drive_en, 0);
    chk("R9 up", ctrl_up, 0);
    rst_n = 1;
    cyc(4);
    chk("R1 nominal on", drive_en, ALL);
    chk("R3 nominal up", ctrl_up, 1);
  endtask

  task automatic t_truth();
    for (int v = 0; v < 8; v++) begin
      laser_rst_n = v[2]; laser_en = v[1]; laser_en_n = v[0];
      cyc(4);
      chk("R1/R2 truth drive", drive_en, (v == 3'b110) ? ALL : '0);
      chk("R3 truth up", ctrl_up, v[2]);
    end
    nominal();
  endtask

  task automatic t_latency();
    laser_en = 0;
    cyc(2);
    chk("R8 still on after 2 edges", drive_en, ALL);
    cyc(1);
    chk("R8 off after 3 edges", drive_en, 0);
    laser_en = 1;
    cyc(2);
    chk("R8 still off after 2 edges", drive_en, 0);
    cyc(1);
    chk("R8 on after 3 edges", drive_en, ALL);
  endtask

  task automatic t_supply();
    supply_ok = 0;
    cyc(4);
    chk("R4 drive", drive_en, 0);
    chk("R4 up", ctrl_up, 0);
    nominal();
    chk("R4 recover", drive_en, ALL);
  endtask

  task automatic t_channels();
    alert_ok = 12'hA5C;
    cyc(1);
    chk("R7 pattern", drive_en, 12'hA5C);
    alert_ok = 12'h001;
    cyc(1);
    chk("R7 single", drive_en, 12'h001);
    laser_en_n = 1;
    cyc(4);
    chk("R7 global off", drive_en, 0);
    nominal();
  endtask

  task automatic t_short_no_fault();
    laser_rst_n = 0;
    cyc(5);
    chk("R6 off while low", drive_en, 0);
    laser_rst_n = 1;
    cyc(4);
    chk("R6 back on", drive_en, ALL);
    chk("R6 up back", ctrl_up, 1);
  endtask

  task automatic t_fault();
    fault_in = 1;
    cyc(4);
    chk("R5 fault drive", drive_en, 0);
    chk("R3 fault up", ctrl_up, 0);
    fault_in = 0;
    cyc(10);
    chk("R5 latched drive", drive_en, 0);
    chk("R5 latched up", ctrl_up, 0);
    laser_rst_n = 0;
    cyc(MIN - 1);
    laser_rst_n = 1;
    cyc(6);
    chk("R6 short pulse keeps fault", ctrl_up, 0);
    chk("R6 short pulse dark", drive_en, 0);
    laser_rst_n = 0;
    cyc(MIN);
    laser_rst_n = 1;
    cyc(6);
    chk("R6 full pulse clears up", ctrl_up, 1);
    chk("R6 full pulse clears drive", drive_en, ALL);
  endtask

  initial begin
    t_reset_state();
    t_truth();
    t_latency();
    t_supply();
    t_channels();
    t_short_no_fault();
    t_fault();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule